// File: doc/BRIEF.md
# Multi-Format Signed Adder/Subtractor

This is a purely combinational 8-bit arithmetic unit. It adds or subtracts two operands that are held in one of three signed number formats: two's complement, ones' complement or sign-magnitude. A 2-bit format input picks the number system. A single control bit picks addition or subtraction.

Subtraction always works the same way. The second operand is first negated in the active format, and the unit then adds. In two's complement the unit also takes a carry/borrow input and gives a carry/borrow output. This lets wider integers be processed one 8-bit word at a time, starting with the least significant word. For every format the unit reports an overflow flag and a zero flag that follows that format's rules.

Top module: `signedFmtAdder`

## Requirements
- R1: Format codes on `fmtSel` are: 2'b00 two's complement, 2'b01 ones' complement, 2'b10 sign-magnitude. Code 2'b11 gives exactly the same outputs as 2'b00.
- R2: Two's complement with `opSub`=0 gives {`carryOut`,`result`} = `opA` + `opB` + `carryIn`, computed as a 9-bit unsigned sum.
- R3: Two's complement with `opSub`=1 gives `result` = (`opA` − `opB` − `carryIn`) mod 256. `carryOut` is a borrow: it is 1 exactly when unsigned `opA` < `opB` + `carryIn`.
- R4: In two's complement, `overflow` is 1 exactly when `opA` and the effective second operand (`opB`, or its negation when subtracting) have the same bit 7 and `result` bit 7 differs from it. Operands of opposite sign never overflow.
- R5: Ones' complement addition forms the 9-bit sum `opA` + `opB`. Its bit 8 (the end-around carry) is added back into bit 0 to give `result`, and that same bit 8 appears on `carryOut`.
- R6: Ones' complement subtraction complements every bit of `opB` and then adds as in R5. `carryIn` has no effect in the ones' complement and sign-magnitude formats.
- R7: In ones' complement, `overflow` uses the sign rule of R4, applied to the result after the end-around carry.
- R8: In sign-magnitude, bit 7 is the sign (1 = negative) and bits 6:0 are the magnitude. Subtraction flips the sign of `opB`. When the two signs are equal, the magnitudes are added and the common sign is kept. A carry out of bit 6 sets both `overflow` and `carryOut`, and the magnitude keeps only its low 7 bits.
- R9: In sign-magnitude with differing signs, the smaller magnitude is subtracted from the larger. The result takes the sign of the operand with the larger magnitude. `overflow` and `carryOut` are 0.
- R10: In sign-magnitude, a zero magnitude always has a positive sign, so `result` is never 8'h80.
- R11: `zero` is 1 when `result` is 8'h00. In ones' complement it is also 1 when `result` is 8'hFF (negative zero).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fmtSel | input | 2 | Number format select |
| opSub | input | 1 | 0 = add, 1 = subtract |
| carryIn | input | 1 | Carry (add) or borrow (subtract) input, two's complement only |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| result | output | 8 | Sum or difference in the selected format |
| carryOut | output | 1 | Carry, borrow or end-around carry, depending on format |
| overflow | output | 1 | Signed overflow for the selected format |
| zero | output | 1 | Result represents zero |

## Verification
The hardest cases to reach are those where zero has two encodings. Examples are a sign-magnitude sum of two negative zeros, a magnitude overflow that wraps to zero, and a ones' complement difference of equal values that lands on all ones. Random operands almost never hit these. The bench therefore drives the exact operand pairs that reach them: 8'h80 plus 8'h80, 8'h40 plus 8'h40, and equal operands subtracted. It then checks that the sign is forced positive and that the zero flag covers the negative-zero pattern. Borrow chaining is reached in a similar way, using equal operands with `carryIn` set. That is the one case where the borrow depends only on the input bit.

// File: rtl/sfaPkg.sv
package sfaPkg;

  typedef enum logic [1:0] {
    FMT_TWOS    = 2'b00,
    FMT_ONES    = 2'b01,
    FMT_SIGNMAG = 2'b10,
    FMT_ALT     = 2'b11
  } fmtSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selTwos;    // two's complement path active
    logic selOnes;    // ones' complement path active
    logic selSm;      // sign-magnitude path active
    logic negB;       // negate second operand in active format
    logic carryInj;   // bit injected into the complement adder
    logic borrowOut;  // report carry as inverted borrow
  } ctrlStrobe_t;

endpackage

// File: rtl/sfaControl.sv
module sfaControl
  import sfaPkg::*;
(
  input  logic        [1:0] fmtSel,
  input  logic              opSub,
  input  logic              carryIn,
  output ctrlStrobe_t       strobe
);

  always_comb begin
    strobe = '0;
    case (fmtSel_e'(fmtSel))
      FMT_ONES:    strobe.selOnes = 1'b1;
      FMT_SIGNMAG: strobe.selSm   = 1'b1;
      default:     strobe.selTwos = 1'b1;
    endcase
    strobe.negB      = opSub;
    // subtract-with-borrow: A + ~B + ~borrow
    strobe.carryInj  = strobe.selTwos & (opSub ^ carryIn);
    strobe.borrowOut = strobe.selTwos & opSub;
  end

endmodule

// File: rtl/sfaDatapath.sv
module sfaDatapath
  import sfaPkg::*;
#(
  parameter int W = 8
) (
  input  ctrlStrobe_t         strobe,
  input  logic        [W-1:0] opA,
  input  logic        [W-1:0] opB,
  output logic        [W-1:0] result,
  output logic                carryOut,
  output logic                overflow,
  output logic                zero
);

  localparam int MW = W - 1;  // magnitude width in sign-magnitude

  // complement adder shared by two's and ones' formats
  logic [W-1:0] bEff;
  logic [W:0]   rawSum;
  logic [W-1:0] onesRes;
  logic [W-1:0] cmpRes;
  logic         cmpOvf;

  assign bEff    = opB ^ {W{strobe.negB}};
  assign rawSum  = {1'b0, opA} + {1'b0, bEff} + {{W{1'b0}}, strobe.carryInj};
  assign onesRes = rawSum[W-1:0] + {{(W-1){1'b0}}, rawSum[W]};
  assign cmpRes  = strobe.selOnes ? onesRes : rawSum[W-1:0];
  assign cmpOvf  = (opA[W-1] == bEff[W-1]) && (cmpRes[W-1] != opA[W-1]);

  // sign-magnitude compare-and-subtract path
  logic          aSign, bSign;
  logic [MW-1:0] aMag, bMag, diffMag, smMag;
  logic [MW:0]   magSum;
  logic          aGe, smSign, smCarry;

  assign aSign   = opA[W-1];
  assign bSign   = opB[W-1] ^ strobe.negB;
  assign aMag    = opA[MW-1:0];
  assign bMag    = opB[MW-1:0];
  assign magSum  = {1'b0, aMag} + {1'b0, bMag};
  assign aGe     = aMag >= bMag;
  assign diffMag = aGe ? (aMag - bMag) : (bMag - aMag);

  always_comb begin
    if (aSign == bSign) begin
      smMag   = magSum[MW-1:0];
      smSign  = aSign;
      smCarry = magSum[MW];
    end else begin
      smMag   = diffMag;
      smSign  = aGe ? aSign : bSign;
      smCarry = 1'b0;
    end
  end

  // output select
  always_comb begin
    if (strobe.selSm) begin
      result   = {smSign & (|smMag), smMag};
      carryOut = smCarry;
      overflow = smCarry;
    end else begin
      result   = cmpRes;
      carryOut = rawSum[W] ^ strobe.borrowOut;
      overflow = cmpOvf;
    end
    zero = (~|result) | (strobe.selOnes & (&result));
  end

endmodule

// File: rtl/signedFmtAdder.sv
module signedFmtAdder
  import sfaPkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   fmtSel,
  input  logic         opSub,
  input  logic         carryIn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result,
  output logic         carryOut,
  output logic         overflow,
  output logic         zero
);

  ctrlStrobe_t strobe;

  sfaControl uCtrl (
    .fmtSel  (fmtSel),
    .opSub   (opSub),
    .carryIn (carryIn),
    .strobe  (strobe)
  );

  sfaDatapath #(.W(W)) uPath (
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow),
    .zero     (zero)
  );

endmodule

// File: rtl/sfaChecker.sv
module sfaChecker #(
  parameter int W = 8
) (
  input logic [1:0]   fmtSel,
  input logic         opSub,
  input logic         carryIn,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [W-1:0] result,
  input logic         carryOut,
  input logic         overflow,
  input logic         zero
);

  logic isOnes, isSm, isTwos;
  logic [W:0] plainSum;

  assign isOnes   = fmtSel == 2'b01;
  assign isSm     = fmtSel == 2'b10;
  assign isTwos   = !isOnes && !isSm;
  assign plainSum = {1'b0, opA} + {1'b0, opB} + {{W{1'b0}}, carryIn};

  always_comb begin
    // R2 and R1: two's add (codes 00 and 11) equals wide unsigned sum
    a_r2_twos_add_sum: assert (!(isTwos && !opSub) || ({carryOut, result} == plainSum))
      else $error("two's add mismatch");
    // R4: opposite effective signs never overflow
    a_r4_twos_mixed_no_ovf: assert (!(isTwos && (opA[W-1] != (opB[W-1] ^ opSub))) || !overflow)
      else $error("two's overflow with mixed signs");
    // R10: no negative zero in sign-magnitude
    a_r10_sm_no_neg_zero: assert (!isSm || (result != {1'b1, {(W-1){1'b0}}}))
      else $error("sign-magnitude negative zero");
    // R8: sign-magnitude carry and overflow agree
    a_r8_sm_carry_ovf: assert (!isSm || (carryOut == overflow))
      else $error("sign-magnitude carry/overflow split");
    // R11: zero flag covers the zero encodings of the format
    a_r11_zero_flag: assert (zero == ((result == '0) || (isOnes && (result == '1))))
      else $error("zero flag mismatch");
  end

endmodule

bind signedFmtAdder sfaChecker #(.W(W)) uChk (
  .fmtSel   (fmtSel),
  .opSub    (opSub),
  .carryIn  (carryIn),
  .opA      (opA),
  .opB      (opB),
  .result   (result),
  .carryOut (carryOut),
  .overflow (overflow),
  .zero     (zero)
);

// File: tb/sim_signedFmtAdder.sv
module sim_signedFmtAdder;

  logic       clk = 1'b0;
  logic [1:0] fmtSel = 2'b00;
  logic       opSub = 1'b0;
  logic       carryIn = 1'b0;
  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic [7:0] result;
  logic       carryOut, overflow, zero;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  signedFmtAdder u0 (
    .fmtSel   (fmtSel),
    .opSub    (opSub),
    .carryIn  (carryIn),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .carryOut (carryOut),
    .overflow (overflow),
    .zero     (zero)
  );

  // drive after a rising edge, sample at the following falling edge
  task automatic run(input string tag, input logic [1:0] f, input logic s, input logic ci,
                     input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] eRes, input logic eC, input logic eV, input logic eZ);
    @(posedge clk);
    #2;
    fmtSel = f; opSub = s; carryIn = ci; opA = a; opB = b;
    @(negedge clk);
    checks++;
    if ({result, carryOut, overflow, zero} !== {eRes, eC, eV, eZ}) begin
      errors++;
      $display("FAIL %s: a=%h b=%h f=%b sub=%b ci=%b got res=%h c=%b v=%b z=%b exp res=%h c=%b v=%b z=%b",
               tag, a, b, f, s, ci, result, carryOut, overflow, zero, eRes, eC, eV, eZ);
    end
  endtask

  task automatic testIdle();
    run("R11 idle zero", 2'b00, 0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 1);
  endtask

  task automatic testTwosAdd();
    run("R2 plain",           2'b00, 0, 0, 8'h10, 8'h20, 8'h30, 0, 0, 0);
    run("R4 pos overflow",    2'b00, 0, 0, 8'h7F, 8'h01, 8'h80, 0, 1, 0);
    run("R2 wrap carry",      2'b00, 0, 0, 8'hFF, 8'h01, 8'h00, 1, 0, 1);
    run("R2 carryIn",         2'b00, 0, 1, 8'hFF, 8'h00, 8'h00, 1, 0, 1);
    run("R4 neg overflow",    2'b00, 0, 0, 8'h80, 8'h80, 8'h00, 1, 1, 1);
  endtask

  task automatic testTwosSub();
    run("R3 no borrow",       2'b00, 1, 0, 8'h30, 8'h10, 8'h20, 0, 0, 0);
    run("R3 borrow",          2'b00, 1, 0, 8'h10, 8'h30, 8'hE0, 1, 0, 0);
    run("R3 borrowIn equal",  2'b00, 1, 1, 8'h05, 8'h05, 8'hFF, 1, 0, 0);
    run("R4 sub overflow",    2'b00, 1, 0, 8'h80, 8'h01, 8'h7F, 0, 1, 0);
    run("R3 zero diff",       2'b00, 1, 0, 8'h00, 8'h00, 8'h00, 0, 0, 1);
  endtask

  task automatic testAltCode();
    run("R1 code11 add",      2'b11, 0, 0, 8'h7F, 8'h01, 8'h80, 0, 1, 0);
    run("R1 code11 sub",      2'b11, 1, 0, 8'h10, 8'h30, 8'hE0, 1, 0, 0);
  endtask

  task automatic testOnes();
    run("R11 ones neg zero",  2'b01, 0, 0, 8'h05, 8'hFA, 8'hFF, 0, 0, 1);
    run("R5 end-around",      2'b01, 0, 0, 8'h06, 8'hFC, 8'h03, 1, 0, 0);
    run("R7 pos overflow",    2'b01, 0, 0, 8'h7F, 8'h01, 8'h80, 0, 1, 0);
    run("R7 neg overflow",    2'b01, 0, 0, 8'h80, 8'hFE, 8'h7F, 1, 1, 0);
    run("R6 sub",             2'b01, 1, 0, 8'h06, 8'h03, 8'h03, 1, 0, 0);
    run("R6 sub carryIn ign", 2'b01, 1, 1, 8'h06, 8'h03, 8'h03, 1, 0, 0);
    run("R6 add carryIn ign", 2'b01, 0, 1, 8'h10, 8'h20, 8'h30, 0, 0, 0);
    run("R11 ones sub equal", 2'b01, 1, 0, 8'h03, 8'h03, 8'hFF, 0, 0, 1);
  endtask

  task automatic testSignMag();
    run("R8 pos add",         2'b10, 0, 0, 8'h05, 8'h03, 8'h08, 0, 0, 0);
    run("R8 neg add",         2'b10, 0, 0, 8'h85, 8'h83, 8'h88, 0, 0, 0);
    run("R9 a larger",        2'b10, 0, 0, 8'h05, 8'h83, 8'h02, 0, 0, 0);
    run("R9 b larger",        2'b10, 0, 0, 8'h03, 8'h85, 8'h82, 0, 0, 0);
    run("R10 equal mags",     2'b10, 0, 0, 8'h85, 8'h05, 8'h00, 0, 0, 1);
    run("R10 ovf to zero",    2'b10, 0, 0, 8'h40, 8'h40, 8'h00, 1, 1, 1);
    run("R8 mag overflow",    2'b10, 0, 0, 8'h70, 8'h20, 8'h10, 1, 1, 0);
    run("R8 sub flips sign",  2'b10, 1, 0, 8'h05, 8'h03, 8'h02, 0, 0, 0);
    run("R8 sub of negative", 2'b10, 1, 0, 8'h05, 8'h83, 8'h08, 0, 0, 0);
    run("R8 sub neg result",  2'b10, 1, 0, 8'h83, 8'h05, 8'h88, 0, 0, 0);
    run("R10 neg zeros",      2'b10, 0, 0, 8'h80, 8'h80, 8'h00, 0, 0, 1);
    run("R6 sm carryIn ign",  2'b10, 0, 1, 8'h05, 8'h03, 8'h08, 0, 0, 0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    testIdle();
    testTwosAdd();
    testTwosSub();
    testAltCode();
    testOnes();
    testSignMag();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule